// File: doc/BRIEF.md
# Interlaced Packed-Pixel Frame Writer

This block plots one pixel at a time into a byte-wide frame memory. A request carries an x and y coordinate, a colour and a mode bit. The block works out which byte holds the pixel, reads that byte, replaces only the bits that belong to the pixel, and writes the byte back. Scanlines are interlaced across two banks. Even lines go in the lower bank and odd lines go in the upper bank, which starts 0x2000 bytes higher. Every line is 80 bytes long.

Two pixel formats are supported. In the two-colour format (mode 0) a byte holds 8 one-bit pixels and a line is 640 pixels wide. In the four-colour format (mode 1) a byte holds 4 two-bit pixels and a line is 320 pixels wide. In both formats the leftmost pixel sits in the most significant end of the byte. The block takes one request at a time over a valid/ready handshake. It drives a synchronous memory port whose read data arrives one cycle after the read strobe.

Top module: `pixel_plot_writer`

## Requirements
- R1: While and after reset, with no request, `req_ready_o` is 1 and both `mem_rd_o` and `mem_wr_o` are 0.
- R2: For an even y in range, the byte address is (y/2)*80 + byte index.
- R3: For an odd y in range, the byte address is 0x2000 + ((y-1)/2)*80 + byte index.
- R4: With `req_mode_i`=0, the byte index is x/8 and the pixel is the single bit at position 7-(x mod 8).
- R5: With `req_mode_i`=1, the byte index is x/4 and the pixel is the 2-bit field whose low bit is at position 6-2*(x mod 4).
- R6: The colour is cut down to the mode's width before it is placed. In mode 0 only `req_color_i[0]` is used, and `req_color_i[1]` has no effect.
- R7: Every bit of the addressed byte outside the pixel's field keeps its old value.
- R8: A request with y>=200, or with x>=640 in mode 0, or with x>=320 in mode 1, is accepted. It causes no memory read or write, and `req_ready_o` stays 1.
- R9: An accepted in-range request causes exactly one read and then exactly one write to the same address. The read strobe comes in the first cycle after acceptance and the write strobe in the third. `req_ready_o` is 0 for exactly those three cycles.
- R10: A request is taken only while `req_ready_o` is 1. A `req_valid_i` pulse that starts and ends while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Plot request valid |
| req_ready_o | output | 1 | Block idle; a request is accepted when valid and ready are both 1 |
| req_x_i | input | 10 | Pixel column |
| req_y_i | input | 8 | Scanline number |
| req_color_i | input | 2 | Pixel colour |
| req_mode_i | input | 1 | 0: one bit per pixel, 640 wide; 1: two bits per pixel, 320 wide |
| mem_addr_o | output | 14 | Frame memory byte address |
| mem_rd_o | output | 1 | Read strobe; data returns on mem_rdata_i one cycle later |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data |

## Verification
The bench starts the memory with random contents, so a merge that clears neighbouring bits or leaves old pixel bits in place changes bytes that the bench compares. The corner cases it targets are these:
- The last column and the last line of each mode. An off-by-one here would either write outside the frame or wrongly drop a valid pixel.
- Columns just past the line end in each mode. A design that checks against the wrong width would write memory here.
- Odd lines. A missing bank offset would land the pixel in the even bank.
- Mono plots with the upper colour bit set. A design that skips the colour cut would corrupt the neighbouring pixel.
- A request pulsed while the block is busy. A design that takes requests without checking ready would make a second write.

// File: rtl/plot_pkg.sv
package plot_pkg;
  localparam int X_W      = 10;
  localparam int Y_W      = 8;
  localparam int COL_W    = 2;
  localparam int ADDR_W   = 14;
  localparam int LINE_B   = 80;
  localparam int BANK_OFS = 'h2000;
  localparam int LINES    = 200;
  localparam int MONO_PX  = 640;
  localparam int QUAD_PX  = 320;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_MRG  = 2'd2,
    ST_WR   = 2'd3
  } plot_state_e;
endpackage

// File: rtl/plot_addr_gen.sv
module plot_addr_gen
  import plot_pkg::*;
#(
  parameter int PX_X_W = X_W,
  parameter int PX_Y_W = Y_W,
  parameter int AW     = ADDR_W
) (
  input  logic [PX_X_W-1:0] x_i,
  input  logic [PX_Y_W-1:0] y_i,
  input  logic              mode_i,
  input  logic [1:0]        color_i,
  output logic [AW-1:0]     addr_o,
  output logic [7:0]        mask_o,
  output logic [7:0]        bits_o,
  output logic              in_range_o
);
  localparam logic [AW-1:0]     LINE_STRIDE = AW'(LINE_B);
  localparam logic [AW-1:0]     BANK_BASE   = AW'(BANK_OFS);
  localparam logic [PX_X_W-1:0] X_LIM_MONO  = PX_X_W'(MONO_PX);
  localparam logic [PX_X_W-1:0] X_LIM_QUAD  = PX_X_W'(QUAD_PX);
  localparam logic [PX_Y_W-1:0] Y_LIM       = PX_Y_W'(LINES);

  logic [AW-1:0] row_base;
  logic [AW-1:0] byte_idx;
  logic [2:0]    shamt;
  logic [7:0]    field;
  logic [7:0]    color_cut;

  always_comb begin
    row_base = AW'(y_i >> 1) * LINE_STRIDE;
    if (mode_i) begin
      byte_idx  = AW'(x_i >> 2);
      shamt     = {~x_i[1:0], 1'b0};
      field     = 8'h03;
      color_cut = {6'd0, color_i};
    end else begin
      byte_idx  = AW'(x_i >> 3);
      shamt     = ~x_i[2:0];
      field     = 8'h01;
      color_cut = {7'd0, color_i[0]};
    end
    addr_o     = (y_i[0] ? BANK_BASE : '0) + row_base + byte_idx;
    mask_o     = field << shamt;
    bits_o     = color_cut << shamt;
    in_range_o = (y_i < Y_LIM) && (x_i < (mode_i ? X_LIM_QUAD : X_LIM_MONO));
  end
endmodule

// File: rtl/plot_merge.sv
module plot_merge (
  input  logic [7:0] old_i,
  input  logic [7:0] mask_i,
  input  logic [7:0] bits_i,
  output logic [7:0] new_o
);
  assign new_o = (old_i & ~mask_i) | (bits_i & mask_i);
endmodule

// File: rtl/plot_ctrl.sv
module plot_ctrl
  import plot_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          in_range_i,
  input  logic          mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    mask_i,
  input  logic [7:0]    bits_i,
  input  logic [7:0]    merged_i,
  output logic          ready_o,
  output logic [7:0]    mask_o,
  output logic [7:0]    bits_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [7:0]    mem_wdata_o
);
  plot_state_e   state_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    mask_q, bits_q, wdata_q;
  logic          mode_q;
  logic          accept;

  assign ready_o     = (state_q == ST_IDLE);
  assign accept      = valid_i && ready_o;
  assign mask_o      = mask_q;
  assign bits_o      = bits_q;
  assign mem_addr_o  = addr_q;
  assign mem_rd_o    = (state_q == ST_RD);
  assign mem_wr_o    = (state_q == ST_WR);
  assign mem_wdata_o = wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      bits_q  <= '0;
      wdata_q <= '0;
      mode_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept && in_range_i) begin
          addr_q  <= addr_i;
          mask_q  <= mask_i;
          bits_q  <= bits_i;
          mode_q  <= mode_i;
          state_q <= ST_RD;
        end
        ST_RD:   state_q <= ST_MRG;
        ST_MRG: begin
          wdata_q <= merged_i;  // read data valid this cycle
          state_q <= ST_WR;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_oor_noaccess_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !in_range_i) |=> (ready_o && !mem_rd_o));
  p_rd_after_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && in_range_i) |=> mem_rd_o);
  p_wr_follows_rd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> ##1 mem_wr_o);
  p_wr_same_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> ##1 $stable(mem_addr_o));
  p_busy_not_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> !ready_o);
  p_field_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> ($countones(mask_q) == (mode_q ? 2 : 1)));
  p_keep_rest_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (((mem_wdata_o ^ $past(merged_i)) & ~mask_q) == 8'd0));
endmodule

// File: rtl/pixel_plot_writer.sv
module pixel_plot_writer
  import plot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [X_W-1:0]    req_x_i,
  input  logic [Y_W-1:0]    req_y_i,
  input  logic [COL_W-1:0]  req_color_i,
  input  logic              req_mode_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  logic [ADDR_W-1:0] gen_addr;
  logic [7:0]        gen_mask, gen_bits, held_mask, held_bits, merged;
  logic              gen_in_range;

  plot_addr_gen #(.PX_X_W(X_W), .PX_Y_W(Y_W), .AW(ADDR_W)) u_addr_gen (
    .x_i        (req_x_i),
    .y_i        (req_y_i),
    .mode_i     (req_mode_i),
    .color_i    (req_color_i),
    .addr_o     (gen_addr),
    .mask_o     (gen_mask),
    .bits_o     (gen_bits),
    .in_range_o (gen_in_range)
  );

  plot_merge u_merge (
    .old_i  (mem_rdata_i),
    .mask_i (held_mask),
    .bits_i (held_bits),
    .new_o  (merged)
  );

  plot_ctrl #(.AW(ADDR_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (req_valid_i),
    .in_range_i  (gen_in_range),
    .mode_i      (req_mode_i),
    .addr_i      (gen_addr),
    .mask_i      (gen_mask),
    .bits_i      (gen_bits),
    .merged_i    (merged),
    .ready_o     (req_ready_o),
    .mask_o      (held_mask),
    .bits_o      (held_bits),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .mem_wdata_o (mem_wdata_o)
  );

  p_wr_in_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_addr_o < ADDR_W'(BANK_OFS + LINES / 2 * LINE_B)));
endmodule

// File: tb/pixel_plot_writer_bench.sv
module pixel_plot_writer_bench;
  import plot_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_SZ     = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, mode = 1'b0;
  logic [X_W-1:0] x = '0;
  logic [Y_W-1:0] y = '0;
  logic [1:0] color = '0;
  logic ready, rd, wr;
  logic [ADDR_W-1:0] addr;
  logic [7:0] wdata, rdata = '0;

  logic [7:0] mem [MEM_SZ];
  logic [7:0] ref_mem [MEM_SZ];
  int n_chk = 0, n_bad = 0, rd_cnt = 0, wr_cnt = 0, cyc = 0;
  logic [ADDR_W-1:0] last_wr_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_plot_writer u_pixel_plot_writer (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_x_i(x), .req_y_i(y), .req_color_i(color), .req_mode_i(mode),
    .mem_addr_o(addr), .mem_rd_o(rd), .mem_wr_o(wr), .mem_wdata_o(wdata),
    .mem_rdata_i(rdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd) begin rdata <= mem[addr]; rd_cnt <= rd_cnt + 1; end
    if (wr) begin mem[addr] <= wdata; wr_cnt <= wr_cnt + 1; last_wr_addr <= addr; end
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit in_frame(input int px, input int py, input bit m);
    return (py < 200) && (px < (m ? 320 : 640));
  endfunction
  function automatic int exp_addr(input int px, input int py, input bit m);
    return (py % 2) * 'h2000 + (py / 2) * 80 + (m ? px / 4 : px / 8);
  endfunction
  function automatic logic [7:0] exp_byte(input logic [7:0] old, input int px,
                                          input bit m, input int c);
    int pos; logic [7:0] fm;
    if (m) begin pos = 6 - 2 * (px % 4); fm = 8'h03 << pos; return (old & ~fm) | 8'((c & 3) << pos); end
    pos = 7 - (px % 8); fm = 8'h01 << pos;
    return (old & ~fm) | 8'((c & 1) << pos);
  endfunction

  task automatic plot(input int px, input int py, input int c, input bit m, input string tag);
    int r0, w0, busy, ea; bit inr;
    inr = in_frame(px, py, m);
    @(negedge clk);
    x = X_W'(px); y = Y_W'(py); color = 2'(c); mode = m; valid = 1'b1;
    r0 = rd_cnt; w0 = wr_cnt;
    @(posedge clk);
    @(negedge clk);
    valid = 1'b0;
    busy = 0;
    while (!ready && busy < 20) begin busy++; @(negedge clk); end
    if (inr) begin
      ea = exp_addr(px, py, m);
      ref_mem[ea] = exp_byte(ref_mem[ea], px, m, c);
      check({tag, " R9 busy cycles"}, busy, 3);
      check({tag, " R9 reads"}, rd_cnt - r0, 1);
      check({tag, " R9 writes"}, wr_cnt - w0, 1);
      check({tag, (py % 2) ? " R3 addr" : " R2 addr"}, int'(last_wr_addr), ea);
      check({tag, m ? " R5 R7 byte" : " R4 R7 byte"}, int'(mem[ea]), int'(ref_mem[ea]));
    end else begin
      check({tag, " R8 busy"}, busy, 0);
      check({tag, " R8 accesses"}, (rd_cnt - r0) + (wr_cnt - w0), 0);
    end
  endtask

  initial begin
    int ea, r0, w0, bad_bytes;
    void'($urandom(32'h1b2c_3d4e));
    for (int i = 0; i < MEM_SZ; i++) begin
      mem[i] = 8'($urandom); ref_mem[i] = mem[i];
    end
    #(CLK_PERIOD * 3);
    check("R1 ready in reset", int'(ready), 1);
    check("R1 strobes in reset", int'(rd | wr), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 ready after reset", int'(ready), 1);
    check("R1 no access after reset", rd_cnt + wr_cnt, 0);

    plot(0, 0, 1, 0, "d_origin_mono");
    plot(639, 199, 1, 0, "d_last_mono");
    plot(640, 0, 1, 0, "d_col_past_mono");
    plot(0, 200, 1, 0, "d_row_past");
    plot(319, 199, 2, 1, "d_last_quad");
    plot(320, 4, 3, 1, "d_col_past_quad");
    plot(1, 1, 3, 1, "d_odd_quad");
    plot(7, 3, 0, 0, "d_odd_mono");
    // R6: upper colour bit ignored in mono; the pixel must read as 0
    plot(13, 6, 2, 0, "d_R6_cut");
    check("R6 mono bit", int'((mem[exp_addr(13, 6, 0)] >> 2) & 1), 0);

    // R10: valid pulse while busy is ignored
    @(negedge clk);
    x = 10'd100; y = 8'd10; color = 2'd3; mode = 1'b1; valid = 1'b1;
    r0 = rd_cnt; w0 = wr_cnt;
    @(posedge clk); @(negedge clk);
    x = 10'd200; y = 8'd20; color = 2'd0; valid = 1'b1;
    @(negedge clk); valid = 1'b0;
    while (!ready) @(negedge clk);
    ea = exp_addr(100, 10, 1);
    ref_mem[ea] = exp_byte(ref_mem[ea], 100, 1, 3);
    check("R10 single write", wr_cnt - w0, 1);
    check("R10 busy pulse ignored", int'(mem[exp_addr(200, 20, 1)]), int'(ref_mem[exp_addr(200, 20, 1)]));

    for (int k = 0; k < 400; k++)
      plot(int'($urandom_range(0, 700)), int'($urandom_range(0, 215)),
           int'($urandom_range(0, 3)), 1'($urandom), "rnd");

    bad_bytes = 0;
    for (int i = 0; i < MEM_SZ; i++) if (mem[i] !== ref_mem[i]) bad_bytes++;
    check("R7 full frame compare", bad_bytes, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule